// File: doc/BRIEF.md
# Indirect Register Access Bridge

This block puts the 8-bit internal registers of a two-wire serial controller behind a single 64-bit command word. A host writes the word with a launch flag, an operation code, a register selector, a direction flag and a data byte. The bridge carries out the internal access one cycle later and then drops the launch flag. The host polls that flag to learn when the access has finished. For a read, the fetched byte comes back in the low byte of the same word.

The host side is a plain register port: a write strobe with a 64-bit word, and a read-back bus that always shows the current command word. While an access is pending, the port has no back-pressure. Instead, any write that arrives while the launch flag is set is dropped. The internal register file is part of the block. It drives the configuration bytes to the protocol engine and shows each access as a one-cycle strobe with a selector code and a direction.

Top module: `ira_bridge`

## Requirements
- R1: After reset, the command word reads 0, the control, clock-control and clock-period bytes are 0, and the status register reads back 0xF8.
- R2: A host write with bit 63 set is captured at the next clock edge. The access runs in the following cycle, and at the end of that cycle bit 63 reads 0.
- R3: A host write that arrives while bit 63 of the stored word is set is ignored. The stored word and the registers behave as if it never happened.
- R4: With operation code 3'b110 in bits 59:57 and selector 1 in bits 34:32, the data register is written from bits 7:0, or read when bit 56 is set.
- R5: With operation code 3'b110 and selector 2, the control register is written, or read when bit 56 is set. Its value appears on `ctl_q`.
- R6: With operation code 3'b110 and selector 3, a write loads the clock-control register (`clkctl_q`) and a read returns the status register.
- R7: Operation code 3'b100 addresses the clock-period register (`period_q`) for both write and read.
- R8: A write with operation code 3'b110 and selector 7 clears the control register and loads the status register with 0xF8. The data, clock-control and clock-period registers are kept.
- R9: Any other operation code, selector 0/4/5/6, or a read of selector 7 changes no register. The access still completes with bit 63 cleared, and a read of this kind returns 0 in bits 7:0.
- R10: When an access completes, bits 62:8 keep the value that was written. A write keeps bits 7:0 as written, and a read replaces bits 7:0 with the fetched byte.
- R11: Each launched access raises `acc_stb` for exactly one cycle. In that cycle, `acc_write` is the inverse of bit 56 and `acc_sel` holds the target code: 0 none, 1 data, 2 control, 3 clock-control, 4 status, 5 clock-period, 6 reset.
- R12: A host write with bit 63 clear is stored as written, and no access is started.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_we | input | 1 | Host write strobe for the command word |
| cmd_wdata | input | 64 | Command word written by the host |
| cmd_rdata | output | 64 | Current command word, as polled by the host |
| acc_stb | output | 1 | One-cycle internal access strobe |
| acc_write | output | 1 | Direction of the current access (1 = write) |
| acc_sel | output | 3 | Target code of the current access |
| ctl_q | output | 8 | Control register to the protocol engine |
| clkctl_q | output | 8 | Clock-control register to the protocol engine |
| period_q | output | 8 | Clock-period register to the protocol engine |

## Verification
Suppose the host write is captured at edge k. The strobe, selector code and direction are then valid between edges k and k+1, and the launch flag still reads 1 in that window. The completed word, the read byte and the register outputs all settle at edge k+1. The bench drives every input on a falling edge and samples once in each of these two windows, so each result is compared in exactly the cycle in which it becomes due. The test of a dropped second write holds the write strobe high across edge k+1 and then reads the data register back through a fresh command.

// File: rtl/ira_pkg.sv
package ira_pkg;
  parameter int CMD_W  = 64;
  parameter int BYTE_W = 8;
  localparam int VALID_BIT = 63;
  localparam int READ_BIT  = 56;
  localparam int OP_HI     = 59;
  localparam int OP_LO     = 57;
  localparam int SEL_HI    = 34;
  localparam int SEL_LO    = 32;
  localparam logic [2:0] OP_EXT    = 3'b110;
  localparam logic [2:0] OP_PERIOD = 3'b100;
  localparam logic [BYTE_W-1:0] STAT_IDLE = 8'hF8;

  typedef enum logic [2:0] {
    TGT_NONE   = 3'd0,
    TGT_DATA   = 3'd1,
    TGT_CTL    = 3'd2,
    TGT_CLKCTL = 3'd3,
    TGT_STAT   = 3'd4,
    TGT_PERIOD = 3'd5,
    TGT_RESET  = 3'd6
  } tgt_e;
endpackage

// File: rtl/ira_decode.sv
module ira_decode
  import ira_pkg::*;
(
  input  logic [2:0] op,
  input  logic [2:0] sel,
  input  logic       rd,
  output tgt_e       tgt
);
  always_comb begin
    tgt = TGT_NONE;
    if (op == OP_PERIOD) begin
      tgt = TGT_PERIOD;
    end else if (op == OP_EXT) begin
      unique case (sel)
        3'd1:    tgt = TGT_DATA;
        3'd2:    tgt = TGT_CTL;
        3'd3:    tgt = rd ? TGT_STAT : TGT_CLKCTL;
        3'd7:    tgt = rd ? TGT_NONE : TGT_RESET;
        default: tgt = TGT_NONE;
      endcase
    end
  end
endmodule

// File: rtl/ira_regfile.sv
module ira_regfile
  import ira_pkg::*;
#(
  parameter int W = BYTE_W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         stb,
  input  logic         wr,
  input  tgt_e         tgt,
  input  logic [W-1:0] wbyte,
  output logic [W-1:0] rbyte,
  output logic [W-1:0] ctl_q,
  output logic [W-1:0] clkctl_q,
  output logic [W-1:0] period_q
);
  logic [W-1:0] data_q, stat_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      data_q   <= '0;
      ctl_q    <= '0;
      clkctl_q <= '0;
      period_q <= '0;
      stat_q   <= STAT_IDLE;
    end else if (stb && wr) begin
      case (tgt)
        TGT_DATA:   data_q   <= wbyte;
        TGT_CTL:    ctl_q    <= wbyte;
        TGT_CLKCTL: clkctl_q <= wbyte;
        TGT_PERIOD: period_q <= wbyte;
        TGT_RESET: begin
          ctl_q  <= '0;
          stat_q <= STAT_IDLE;
        end
        default: ;
      endcase
    end
  end

  always_comb begin
    case (tgt)
      TGT_DATA:   rbyte = data_q;
      TGT_CTL:    rbyte = ctl_q;
      TGT_STAT:   rbyte = stat_q;
      TGT_PERIOD: rbyte = period_q;
      default:    rbyte = '0;
    endcase
  end

  // R8: soft reset leaves control clear and status idle
  a_r8_soft_reset: assert property (@(posedge clk) disable iff (!rst_n)
    (stb && wr && tgt == TGT_RESET) |=> (ctl_q == '0 && stat_q == STAT_IDLE));
  // R9: an access with no target touches no register
  a_r9_no_side_effect: assert property (@(posedge clk) disable iff (!rst_n)
    (stb && tgt == TGT_NONE) |=> ($stable(data_q) && $stable(ctl_q) &&
      $stable(clkctl_q) && $stable(period_q) && $stable(stat_q)));
  // R7: period register follows a period write
  a_r7_period_write: assert property (@(posedge clk) disable iff (!rst_n)
    (stb && wr && tgt == TGT_PERIOD) |=> period_q == $past(wbyte));
endmodule

// File: rtl/ira_cmd_reg.sv
module ira_cmd_reg
  import ira_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [CMD_W-1:0]  wdata,
  input  logic [BYTE_W-1:0] rbyte,
  output logic [CMD_W-1:0]  cmd_q
);
  logic busy;
  assign busy = cmd_q[VALID_BIT];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cmd_q <= '0;
    end else if (busy) begin
      cmd_q[VALID_BIT] <= 1'b0;
      if (cmd_q[READ_BIT]) cmd_q[BYTE_W-1:0] <= rbyte;
    end else if (we) begin
      cmd_q <= wdata;
    end
  end

  // R2: a pending access completes after one cycle
  a_r2_valid_clears: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> !cmd_q[VALID_BIT]);
  // R3 / R10: the middle of the word is frozen while an access is pending
  a_r3_ignore_busy: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> cmd_q[CMD_W-2:BYTE_W] == $past(cmd_q[CMD_W-2:BYTE_W]));
  // R10: a write access leaves the data byte untouched
  a_r10_write_keeps_byte: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !cmd_q[READ_BIT]) |=> $stable(cmd_q[BYTE_W-1:0]));
endmodule

// File: rtl/ira_bridge.sv
module ira_bridge
  import ira_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_we,
  input  logic [CMD_W-1:0]  cmd_wdata,
  output logic [CMD_W-1:0]  cmd_rdata,
  output logic              acc_stb,
  output logic              acc_write,
  output logic [2:0]        acc_sel,
  output logic [BYTE_W-1:0] ctl_q,
  output logic [BYTE_W-1:0] clkctl_q,
  output logic [BYTE_W-1:0] period_q
);
  logic [CMD_W-1:0]  cmd_q;
  logic [BYTE_W-1:0] rbyte;
  tgt_e              tgt;

  ira_cmd_reg u_cmd (
    .clk(clk), .rst_n(rst_n), .we(cmd_we), .wdata(cmd_wdata),
    .rbyte(rbyte), .cmd_q(cmd_q)
  );

  ira_decode u_dec (
    .op(cmd_q[OP_HI:OP_LO]), .sel(cmd_q[SEL_HI:SEL_LO]),
    .rd(cmd_q[READ_BIT]), .tgt(tgt)
  );

  ira_regfile #(.W(BYTE_W)) u_rf (
    .clk(clk), .rst_n(rst_n), .stb(acc_stb), .wr(acc_write), .tgt(tgt),
    .wbyte(cmd_q[BYTE_W-1:0]), .rbyte(rbyte), .ctl_q(ctl_q),
    .clkctl_q(clkctl_q), .period_q(period_q)
  );

  assign acc_stb   = cmd_q[VALID_BIT];
  assign acc_write = !cmd_q[READ_BIT];
  assign acc_sel   = tgt;
  assign cmd_rdata = cmd_q;

  // R11: the access strobe is a single-cycle pulse
  a_r11_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    acc_stb |=> !acc_stb);
  // R12: a stored word without the launch flag starts nothing
  a_r12_no_launch: assert property (@(posedge clk) disable iff (!rst_n)
    (!acc_stb && cmd_we && !cmd_wdata[VALID_BIT]) |=> !acc_stb);
endmodule

// File: tb/ira_bridge_tb.sv
module ira_bridge_tb;
  logic        clk = 0;
  logic        rst_n = 0;
  logic        cmd_we = 0;
  logic [63:0] cmd_wdata = '0;
  logic [63:0] cmd_rdata;
  logic        acc_stb, acc_write;
  logic [2:0]  acc_sel;
  logic [7:0]  ctl_q, clkctl_q, period_q;

  int checks = 0, errors = 0;
  logic [7:0] m_data = 0, m_ctl = 0, m_clk = 0, m_per = 0, m_stat = 8'hF8;

  ira_bridge u_dut (.*);

  always #5 clk = ~clk;

  initial begin
    #1_000_000;
    errors++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [63:0] mk(input logic v, input logic [2:0] op,
      input logic rd, input logic [2:0] sel, input logic [7:0] b, input logic [22:0] pad);
    logic [63:0] w;
    w = '0;
    w[63] = v; w[59:57] = op; w[56] = rd; w[34:32] = sel; w[7:0] = b;
    w[31:9] = pad;
    return w;
  endfunction

  function automatic logic [2:0] exp_sel(input logic [2:0] op, input logic [2:0] sel, input logic rd);
    if (op == 3'b100) return 3'd5;
    if (op != 3'b110) return 3'd0;
    case (sel)
      3'd1: return 3'd1;
      3'd2: return 3'd2;
      3'd3: return rd ? 3'd4 : 3'd3;
      3'd7: return rd ? 3'd0 : 3'd6;
      default: return 3'd0;
    endcase
  endfunction

  function automatic logic [7:0] model_rd(input logic [2:0] code);
    case (code)
      3'd1: return m_data;
      3'd2: return m_ctl;
      3'd4: return m_stat;
      3'd5: return m_per;
      default: return 8'h00;
    endcase
  endfunction

  task automatic model_wr(input logic [2:0] code, input logic [7:0] b);
    case (code)
      3'd1: m_data = b;
      3'd2: m_ctl = b;
      3'd3: m_clk = b;
      3'd5: m_per = b;
      3'd6: begin m_ctl = 0; m_stat = 8'hF8; end
      default: ;
    endcase
  endtask

  task automatic run(input string tag, input logic [63:0] w);
    logic [2:0] code;
    logic [63:0] exp;
    code = exp_sel(w[59:57], w[34:32], w[56]);
    @(negedge clk); cmd_we = 1; cmd_wdata = w;
    @(negedge clk); cmd_we = 0;
    chk({tag, " R2 valid set"}, {63'b0, cmd_rdata[63]}, 64'd1);
    chk({tag, " R11 stb/dir/sel"}, {59'b0, acc_stb, acc_write, acc_sel},
        {59'b0, 1'b1, ~w[56], code});
    exp = w; exp[63] = 0;
    if (w[56]) exp[7:0] = model_rd(code); else model_wr(code, w[7:0]);
    @(negedge clk);
    chk({tag, " R2 R10 word"}, cmd_rdata, exp);
    chk({tag, " R5 R6 R7 regs"}, {40'b0, ctl_q, clkctl_q, period_q},
        {40'b0, m_ctl, m_clk, m_per});
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R1 reset word", cmd_rdata, 64'd0);
    chk("R1 reset regs", {40'b0, ctl_q, clkctl_q, period_q}, 64'd0);
    run("R1 status idle", mk(1, 3'b110, 1, 3'd3, 8'h00, 23'h0));
    run("R4 data write", mk(1, 3'b110, 0, 3'd1, 8'hA5, 23'h12345));
    run("R4 data read", mk(1, 3'b110, 1, 3'd1, 8'h3C, 23'h7ABCD));
    run("R5 ctl write", mk(1, 3'b110, 0, 3'd2, 8'h44, 23'h0));
    run("R6 clkctl write", mk(1, 3'b110, 0, 3'd3, 8'h2B, 23'h0));
    run("R7 period write", mk(1, 3'b100, 0, 3'd0, 8'h18, 23'h0));
    run("R7 period read", mk(1, 3'b100, 1, 3'd0, 8'h00, 23'h1));
    run("R8 soft reset", mk(1, 3'b110, 0, 3'd7, 8'hFF, 23'h0));
    run("R8 status after", mk(1, 3'b110, 1, 3'd3, 8'h00, 23'h0));
    run("R9 bad op write", mk(1, 3'b010, 0, 3'd1, 8'h99, 23'h0));
    run("R9 bad sel read", mk(1, 3'b110, 1, 3'd5, 8'h77, 23'h0));
    run("R9 read sel7", mk(1, 3'b110, 1, 3'd7, 8'h66, 23'h0));
    run("R4 data kept", mk(1, 3'b110, 1, 3'd1, 8'h00, 23'h0));

    // R12: word without launch flag
    @(negedge clk); cmd_we = 1; cmd_wdata = mk(0, 3'b110, 0, 3'd1, 8'h5A, 23'h55);
    @(negedge clk); cmd_we = 0;
    chk("R12 no strobe", {63'b0, acc_stb}, 64'd0);
    chk("R12 stored", cmd_rdata, mk(0, 3'b110, 0, 3'd1, 8'h5A, 23'h55));
    run("R12 data unchanged", mk(1, 3'b110, 1, 3'd1, 8'h00, 23'h0));

    // R3: back-to-back write while busy is dropped
    @(negedge clk); cmd_we = 1; cmd_wdata = mk(1, 3'b110, 0, 3'd1, 8'h11, 23'h0);
    @(negedge clk); cmd_wdata = mk(1, 3'b110, 0, 3'd1, 8'h22, 23'h3);
    @(negedge clk); cmd_we = 0;
    m_data = 8'h11;
    chk("R3 word kept", cmd_rdata, mk(0, 3'b110, 0, 3'd1, 8'h11, 23'h0));
    @(negedge clk);
    chk("R3 no relaunch", {63'b0, acc_stb}, 64'd0);
    run("R3 data readback", mk(1, 3'b110, 1, 3'd1, 8'h00, 23'h0));

    // random mix
    begin
      int seed;
      logic [2:0] op;
      seed = 32'h1234;
      void'($urandom(seed));
      for (int i = 0; i < 200; i++) begin
        op = ($urandom % 4 == 0) ? 3'($urandom) : (($urandom % 3 == 0) ? 3'b100 : 3'b110);
        run("RND", mk(1, op, 1'($urandom), 3'($urandom), 8'($urandom), 23'($urandom)));
      end
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule